// File: doc/BRIEF.md
# Integer ALU with Selectable Shift Source

This block is the arithmetic and logic unit of a 32-bit load/store integer datapath. It has no state. In the same evaluation it forms a result word and three flags from two operands and an operation code. The flags are a zero indication, a signed overflow indication and an adder carry-out.

Operand A is always the value that is added to, compared or shifted. Operand B is the addend, the subtrahend, the second compare value, the second logic input, or the carrier of a shift count. The left shift takes its count from one of two places, selected by the operation code: the low bits of operand B, or a separate immediate count field that the instruction decoder supplies.

Compare-less-than reuses the subtractor. Its answer is taken from the difference sign after correction for overflow. Decoding, register access, immediate extension and memory access are handled outside this block.

Top module: `int_alu_core`

## Requirements
- R1: Operation code 4'b0000 (add) gives result = A + B modulo 2^32, and carry_flag equals the carry out of bit 31.
- R2: Operation code 4'b0001 (subtract) gives result = A - B modulo 2^32, and carry_flag is 1 exactly when A >= B as unsigned numbers, meaning no borrow.
- R3: ovf_flag is 1 only for add and subtract, and only when the true signed two's-complement result lies outside the 32-bit range. It is 0 for every other code.
- R4: Operation code 4'b0010 gives the bitwise AND of A and B. Operation code 4'b0011 gives the bitwise OR.
- R5: Operation code 4'b0100 (set-less-than) gives result 1 when A < B as signed numbers and 0 otherwise. This holds also when A - B overflows, and bits 31..1 of the result are always 0.
- R6: Operation code 4'b0101 shifts A left by B[4:0] and fills the vacated bits with zeros. B[31:5] and shift_imm have no effect.
- R7: Operation code 4'b0110 shifts A left by shift_imm and fills the vacated bits with zeros. Operand B has no effect.
- R8: zero_flag is 1 exactly when all 32 result bits are 0, for every operation code.
- R9: carry_flag is 0 for every code other than add and subtract.
- R10: Codes 4'b0111 to 4'b1111 are undefined. They give result 0, ovf_flag 0 and carry_flag 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, or the register shift count in its low 5 bits |
| shift_imm | input | 5 | Shift count taken from the instruction |
| result | output | 32 | Result word |
| zero_flag | output | 1 | Result is all zeros |
| ovf_flag | output | 1 | Signed overflow of add or subtract |
| carry_flag | output | 1 | Adder carry-out for add or subtract |

## Verification
The unit is purely combinational, so every output is due in the same cycle as the stimulus that produces it, with no register in between. The bench drives each new operand set just after a rising clock edge. It reads the result and the three flags at the following falling edge, once the logic has settled. It never waits for an extra cycle and never compares against a stale output.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_SUB  = 4'b0001,
    OP_AND  = 4'b0010,
    OP_OR   = 4'b0011,
    OP_SLT  = 4'b0100,
    OP_SHLR = 4'b0101,
    OP_SHLI = 4'b0110
  } alu_op_e;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf,
  output logic         lt
);
  // Ripple-free behavioural add with explicit carry in.
  function automatic logic [W:0] add_ci(input logic [W-1:0] x, input logic [W-1:0] y,
                                        input logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  logic [W-1:0] b_eff;
  assign b_eff       = sub ? ~b : b;
  assign {cout, sum} = add_ci(a, b_eff, sub);
  assign ovf         = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  // Signed less-than: difference sign corrected by overflow.
  assign lt          = sum[W-1] ^ ovf;
endmodule

// File: rtl/int_alu_shl.sv
module int_alu_shl #(
  parameter int W   = 32,
  parameter int SHW = 5
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   dout
);
  logic [W-1:0] stage [0:SHW];
  assign stage[0] = din;
  for (genvar g = 0; g < SHW; g++) begin : g_stage
    assign stage[g+1] = amt[g] ? (stage[g] << (2 ** g)) : stage[g];
  end
  assign dout = stage[SHW];
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_or,
  output logic [W-1:0] y
);
  assign y = sel_or ? (a | b) : (a & b);
endmodule

// File: rtl/int_alu_core.sv
module int_alu_core #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [3:0]     op_sel,
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic [SHW-1:0] shift_imm,
  output logic [W-1:0]   result,
  output logic           zero_flag,
  output logic           ovf_flag,
  output logic           carry_flag
);
  import int_alu_pkg::*;

  alu_op_e      op;
  logic         is_arith;
  logic         use_sub;
  logic [SHW-1:0] shift_amt;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic         add_ovf;
  logic         add_lt;
  logic [W-1:0] shl_out;
  logic [W-1:0] logic_out;

  assign op        = alu_op_e'(op_sel);
  assign is_arith  = (op == OP_ADD) || (op == OP_SUB);
  assign use_sub   = (op == OP_SUB) || (op == OP_SLT);
  assign shift_amt = (op == OP_SHLR) ? opnd_b[SHW-1:0] : shift_imm;

  int_alu_addsub #(.W(W)) addsub_i (
    .a(opnd_a), .b(opnd_b), .sub(use_sub),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf), .lt(add_lt)
  );

  int_alu_shl #(.W(W), .SHW(SHW)) shl_i (
    .din(opnd_a), .amt(shift_amt), .dout(shl_out)
  );

  int_alu_logic #(.W(W)) logic_i (
    .a(opnd_a), .b(opnd_b), .sel_or(op == OP_OR), .y(logic_out)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:   result = add_sum;
      OP_AND, OP_OR:    result = logic_out;
      OP_SLT:           result = {{(W-1){1'b0}}, add_lt};
      OP_SHLR, OP_SHLI: result = shl_out;
      default:          result = '0;
    endcase
  end

  assign zero_flag  = ~|result;
  assign ovf_flag   = is_arith & add_ovf;
  assign carry_flag = is_arith & add_cout;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int W   = 32,
  parameter int SHW = 5
) (
  input logic [3:0]     op_sel,
  input logic [W-1:0]   opnd_a,
  input logic [W-1:0]   opnd_b,
  input logic [W-1:0]   result,
  input logic           zero_flag,
  input logic           ovf_flag,
  input logic           carry_flag,
  input logic [SHW-1:0] shift_amt
);
  import int_alu_pkg::*;

  logic [W-1:0] low_mask;
  assign low_mask = ({{(W-1){1'b0}}, 1'b1} << shift_amt) - {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    assert_ovf_scope_R3: assert (!ovf_flag || op_sel == OP_ADD || op_sel == OP_SUB);
    assert_carry_scope_R9: assert (!carry_flag || op_sel == OP_ADD || op_sel == OP_SUB);
    assert_and_subset_R4: assert (op_sel != OP_AND ||
                                  ((result & ~opnd_a) == '0 && (result & ~opnd_b) == '0));
    assert_or_cover_R4: assert (op_sel != OP_OR ||
                                ((result & opnd_a) == opnd_a && (result & opnd_b) == opnd_b));
    assert_slt_bool_R5: assert (op_sel != OP_SLT || result[W-1:1] == '0);
    assert_shl_fill_R6: assert (!(op_sel == OP_SHLR || op_sel == OP_SHLI) ||
                                (result & low_mask) == '0);
    assert_sub_equal_R8: assert (!(op_sel == OP_SUB && opnd_a == opnd_b) ||
                                 (zero_flag && carry_flag));
    assert_bad_op_R10: assert (op_sel < 4'd7 || (result == '0 && !ovf_flag && !carry_flag));
  end
endmodule

bind int_alu_core int_alu_chk #(.W(W), .SHW(SHW)) chk_i (
  .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
  .zero_flag(zero_flag), .ovf_flag(ovf_flag), .carry_flag(carry_flag),
  .shift_amt(shift_amt)
);

// File: tb/int_alu_core_tb_top.sv
module int_alu_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0, result;
  logic [4:0]  shift_imm = '0;
  logic        zero_flag, ovf_flag, carry_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int_alu_core dut_i (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .shift_imm(shift_imm),
    .result(result), .zero_flag(zero_flag), .ovf_flag(ovf_flag), .carry_flag(carry_flag)
  );

  // {req, op, a, b, shift_imm, result, {zero,ovf,carry}}
  localparam logic [111:0] VECS [21] = '{
    {4'd1,  4'h0, 32'h00000005, 32'h00000007, 5'd0,  32'h0000000C, 3'b000}, // R1
    {4'd3,  4'h0, 32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 3'b010}, // R3
    {4'd1,  4'h0, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000, 3'b101}, // R1
    {4'd3,  4'h0, 32'h80000000, 32'h80000000, 5'd0,  32'h00000000, 3'b111}, // R3
    {4'd2,  4'h1, 32'h0000000A, 32'h00000003, 5'd0,  32'h00000007, 3'b001}, // R2
    {4'd2,  4'h1, 32'h00000003, 32'h0000000A, 5'd0,  32'hFFFFFFF9, 3'b000}, // R2
    {4'd3,  4'h1, 32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 3'b011}, // R3
    {4'd8,  4'h1, 32'h00001234, 32'h00001234, 5'd0,  32'h00000000, 3'b101}, // R8
    {4'd4,  4'h2, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'hF000F000, 3'b000}, // R4
    {4'd4,  4'h3, 32'hF0F0F0F0, 32'h0F0F0000, 5'd0,  32'hFFFFF0F0, 3'b000}, // R4
    {4'd8,  4'h2, 32'h0000000F, 32'h000000F0, 5'd0,  32'h00000000, 3'b100}, // R8
    {4'd5,  4'h4, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000001, 3'b000}, // R5
    {4'd5,  4'h4, 32'h00000001, 32'hFFFFFFFF, 5'd0,  32'h00000000, 3'b100}, // R5
    {4'd5,  4'h4, 32'h80000000, 32'h7FFFFFFF, 5'd0,  32'h00000001, 3'b000}, // R5
    {4'd5,  4'h4, 32'h7FFFFFFF, 32'h80000000, 5'd0,  32'h00000000, 3'b100}, // R5
    {4'd6,  4'h5, 32'h00000001, 32'h00000025, 5'd9,  32'h00000020, 3'b000}, // R6
    {4'd6,  4'h5, 32'h80000001, 32'h0000001F, 5'd0,  32'h80000000, 3'b000}, // R6
    {4'd7,  4'h6, 32'h00000003, 32'h00000007, 5'd4,  32'h00000030, 3'b000}, // R7
    {4'd7,  4'h6, 32'hFFFFFFFF, 32'h0000001F, 5'd0,  32'hFFFFFFFF, 3'b000}, // R7
    {4'd9,  4'h5, 32'h00000002, 32'h0000001F, 5'd0,  32'h00000000, 3'b100}, // R9
    {4'd10, 4'hF, 32'h00000005, 32'h00000005, 5'd3,  32'h00000000, 3'b100}  // R10
  };

  function automatic logic [34:0] ref_model(input logic [3:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [4:0] sh);
    logic [31:0] r = '0;
    logic v = 1'b0, c = 1'b0;
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint t;
    case (op)
      4'h0: begin r = a + b; t = sa + sb; c = ({1'b0, a} + {1'b0, b}) > 33'hFFFFFFFF;
                  v = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      4'h1: begin r = a - b; t = sa - sb; c = (a >= b);
                  v = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      4'h2: r = a & b;
      4'h3: r = a | b;
      4'h4: r = (sa < sb) ? 32'd1 : 32'd0;
      4'h5: r = a << b[4:0];
      4'h6: r = a << sh;
      default: r = '0;
    endcase
    return {r, (r == 32'd0), v, c};
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh);
    @(posedge clk);
    #1;
    op_sel = op; opnd_a = a; opnd_b = b; shift_imm = sh;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [34:0] m;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: zero operands with add give a zero result (R8, R1)
    apply(4'h0, 32'd0, 32'd0, 5'd0);
    check32("R8 reset zero_flag", {31'd0, zero_flag}, 32'd1);
    check32("R1 reset result", result, 32'd0);

    for (int i = 0; i < 21; i++) begin
      logic [111:0] v = VECS[i];
      apply(v[107:104], v[103:72], v[71:40], v[39:35]);
      check32($sformatf("R%0d vec%0d result", v[111:108], i), result, v[34:3]);
      check32($sformatf("R%0d vec%0d flags", v[111:108], i),
              {29'd0, zero_flag, ovf_flag, carry_flag}, {29'd0, v[2:0]});
    end

    // Directed: R6 high bits of B ignored, R7 B ignored
    apply(4'h5, 32'h00000003, 32'hFFFFFFE4, 5'd17);
    check32("R6 high count bits ignored", result, 32'h00000030);
    apply(4'h6, 32'h00000003, 32'hDEADBEEF, 5'd4);
    check32("R7 operand B ignored", result, 32'h00000030);
    // R10 every undefined code
    for (int k = 7; k < 16; k++) begin
      apply(4'(k), 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd31);
      check32("R10 undefined code", {result[31:2], ovf_flag, carry_flag}, 32'd0);
    end

    // Pseudo-random sweep against the bench model (R1..R9)
    for (int n = 0; n < 400; n++) begin
      logic [3:0] op = 4'($urandom_range(0, 6));
      logic [31:0] a = $urandom;
      logic [31:0] b = (n % 5 == 0) ? a : $urandom;
      logic [4:0] sh = 5'($urandom);
      apply(op, a, b, sh);
      m = ref_model(op, a, b, sh);
      check32($sformatf("R1-model op%0d result", op), result, m[34:3]);
      check32("R3 R8 R9 model flags", {29'd0, zero_flag, ovf_flag, carry_flag},
              {29'd0, m[2:0]});
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule